// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors signal each other through per-channel flags. Each processor reaches the block through its own simple register port, A or B. The port has four registers: a control register, a mask register, a write-only set/clear register and a read-only status register. To announce a message on a channel, a processor sets its own flag for that channel. The other processor acknowledges the message by clearing that flag, which it does through its own port.

Each port drives two level interrupt lines, and both are registered.

- The receive line is active while the peer holds a flag on a channel that this port has not masked.
- The transmit line is active while this port's own flag on a channel is clear and that channel is not masked for transmit.

Flags, masks and enables live in the block. Shared message memory is outside the block.

Top module: `mailbox_flag_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all flags are 0, every mask bit is 1, both enables of each port are 0, and all four interrupt outputs are 0.
- R2: A write at address 0 (control) stores bit 0 as the receive enable and bit 1 as the transmit enable. A write at address 1 (mask) stores bits [NCH-1:0] as the receive (occupied) mask and bits [2*NCH-1:NCH] as the transmit (free) mask. A read returns these fields in the same positions with all other bits 0, and rdata is valid one cycle after the read is presented.
- R3: A write at address 2 (set/clear) raises this port's own flag for every channel whose bit in wdata[2*NCH-1:NCH] is 1. A 0 bit has no effect.
- R4: A write at address 2 clears the peer's flag for every channel whose bit in wdata[NCH-1:0] is 1. It never changes this port's own flags, and a 0 bit has no effect.
- R5: A read at address 3 (status) returns this port's own flags in bits [NCH-1:0]. A write at address 3 has no effect.
- R6: A read at address 2 returns 0.
- R7: The receive interrupt of a port is 1 exactly when its receive enable is 1 and some channel has the peer flag set with the occupied mask bit 0. It follows the state one cycle later.
- R8: The transmit interrupt of a port is 1 exactly when its transmit enable is 1 and some channel has the own flag clear with the free mask bit 0. It follows the state one cycle later.
- R9: When the owner sets a flag and the peer clears the same flag in the same cycle, the set wins and the flag ends up 1.
- R10: Register writes on one port never change the other port's control or mask registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sel | input | 1 | Port A access strobe |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 2 | Port A register address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data, registered |
| b_sel | input | 1 | Port B access strobe |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | 2 | Port B register address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data, registered |
| a_rx_irq | output | 1 | Port A receive-occupied interrupt |
| a_tx_irq | output | 1 | Port A transmit-free interrupt |
| b_rx_irq | output | 1 | Port B receive-occupied interrupt |
| b_tx_irq | output | 1 | Port B transmit-free interrupt |

## Verification
Some properties are checked on every cycle:
- the reset values;
- that a set write leaves its flags raised, including when it meets a peer clear in the same cycle;
- that an unset-by-peer clear drops the flag;
- that flags hold when no set/clear write occurs;
- that the set/clear register reads 0;
- that each interrupt follows its enable and its unmasked channel condition.

Other behaviour only the bench scenarios can show, by comparing register read-back and interrupt levels with a model over random mixes of traffic on both ports:
- exact read-back of the control and mask fields;
- that status writes are ignored;
- that each port's configuration stays separate from the other's.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_MASK   = 2'd1,
    REG_SETCLR = 2'd2,
    REG_STATUS = 2'd3
  } mbox_reg_e;
endpackage

// File: rtl/mbox_port_regs.sv
module mbox_port_regs
  import mbox_pkg::*;
#(
  parameter int NCH = 6,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sel,
  input  logic           we,
  input  logic [1:0]     addr,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] own_flags,
  output logic           rx_en,
  output logic           tx_en,
  output logic [NCH-1:0] occ_msk,
  output logic [NCH-1:0] free_msk,
  output logic [NCH-1:0] set_req,
  output logic [NCH-1:0] clr_req,
  output logic [DW-1:0]  rdata
);
  localparam int MW = 2 * NCH;

  mbox_reg_e reg_sel;
  logic      wr_hit, rd_hit;
  logic [DW-1:0] rd_mux;

  assign reg_sel = mbox_reg_e'(addr);
  assign wr_hit  = sel && we;
  assign rd_hit  = sel && !we;

  // set/clear strobes are combinational pulses into the flag bank
  assign set_req = (wr_hit && reg_sel == REG_SETCLR) ? wdata[MW-1:NCH] : '0;
  assign clr_req = (wr_hit && reg_sel == REG_SETCLR) ? wdata[NCH-1:0]  : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
      occ_msk  <= '1;
      free_msk <= '1;
    end else if (wr_hit) begin
      if (reg_sel == REG_CTRL) begin
        rx_en <= wdata[0];
        tx_en <= wdata[1];
      end
      if (reg_sel == REG_MASK) begin
        occ_msk  <= wdata[NCH-1:0];
        free_msk <= wdata[MW-1:NCH];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_sel)
      REG_CTRL:   rd_mux[1:0]      = {tx_en, rx_en};
      REG_MASK:   rd_mux[MW-1:0]   = {free_msk, occ_msk};
      REG_STATUS: rd_mux[NCH-1:0]  = own_flags;
      default:    rd_mux           = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (rd_hit) rdata <= rd_mux;
    else             rdata <= '0;
  end
endmodule

// File: rtl/mbox_flag_bank.sv
module mbox_flag_bank #(
  parameter int NCH = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0][NCH-1:0] set_req,
  input  logic [1:0][NCH-1:0] clr_req,
  output logic [1:0][NCH-1:0] flags
);
  // flags[p] is owned by port p: set by p, cleared by the peer.
  // Set has priority over a same-cycle clear.
  for (genvar p = 0; p < 2; p++) begin : g_owner
    always_ff @(posedge clk) begin
      if (rst) flags[p] <= '0;
      else     flags[p] <= (flags[p] & ~clr_req[1-p]) | set_req[p];
    end
  end
endmodule

// File: rtl/mbox_irq_gen.sv
module mbox_irq_gen #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_en,
  input  logic           tx_en,
  input  logic [NCH-1:0] own_flags,
  input  logic [NCH-1:0] peer_flags,
  input  logic [NCH-1:0] occ_msk,
  input  logic [NCH-1:0] free_msk,
  output logic           rx_irq,
  output logic           tx_irq
);
  logic rx_any, tx_any;
  assign rx_any = |(peer_flags & ~occ_msk);
  assign tx_any = |(~own_flags & ~free_msk);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_irq <= 1'b0;
      tx_irq <= 1'b0;
    end else begin
      rx_irq <= rx_en && rx_any;
      tx_irq <= tx_en && tx_any;
    end
  end
endmodule

// File: rtl/mailbox_flag_ctrl.sv
module mailbox_flag_ctrl #(
  parameter int NCH = 6,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_sel,
  input  logic          a_we,
  input  logic [1:0]    a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_sel,
  input  logic          b_we,
  input  logic [1:0]    b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          a_rx_irq,
  output logic          a_tx_irq,
  output logic          b_rx_irq,
  output logic          b_tx_irq
);
  logic [1:0]           sel_v, we_v;
  logic [1:0][1:0]      addr_v;
  logic [1:0][DW-1:0]   wdata_v, rdata_v;
  logic [1:0]           rx_en, tx_en, rx_irq_v, tx_irq_v;
  logic [1:0][NCH-1:0]  occ_msk, free_msk, set_req, clr_req, flags;

  assign sel_v   = {b_sel, a_sel};
  assign we_v    = {b_we, a_we};
  assign addr_v  = {b_addr, a_addr};
  assign wdata_v = {b_wdata, a_wdata};
  assign a_rdata = rdata_v[0];
  assign b_rdata = rdata_v[1];
  assign a_rx_irq = rx_irq_v[0];
  assign a_tx_irq = tx_irq_v[0];
  assign b_rx_irq = rx_irq_v[1];
  assign b_tx_irq = tx_irq_v[1];

  for (genvar p = 0; p < 2; p++) begin : g_port
    mbox_port_regs #(.NCH(NCH), .DW(DW)) u_regs (
      .clk(clk), .rst(rst),
      .sel(sel_v[p]), .we(we_v[p]), .addr(addr_v[p]), .wdata(wdata_v[p]),
      .own_flags(flags[p]),
      .rx_en(rx_en[p]), .tx_en(tx_en[p]),
      .occ_msk(occ_msk[p]), .free_msk(free_msk[p]),
      .set_req(set_req[p]), .clr_req(clr_req[p]),
      .rdata(rdata_v[p])
    );

    mbox_irq_gen #(.NCH(NCH)) u_irq (
      .clk(clk), .rst(rst),
      .rx_en(rx_en[p]), .tx_en(tx_en[p]),
      .own_flags(flags[p]), .peer_flags(flags[1-p]),
      .occ_msk(occ_msk[p]), .free_msk(free_msk[p]),
      .rx_irq(rx_irq_v[p]), .tx_irq(tx_irq_v[p])
    );
  end

  mbox_flag_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst(rst),
    .set_req(set_req), .clr_req(clr_req),
    .flags(flags)
  );
endmodule

// File: rtl/mailbox_flag_ctrl_chk.sv
module mailbox_flag_ctrl_chk #(
  parameter int NCH = 6,
  parameter int DW  = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                a_sel,
  input logic                a_we,
  input logic [1:0]          a_addr,
  input logic [DW-1:0]       a_wdata,
  input logic [DW-1:0]       a_rdata,
  input logic                b_sel,
  input logic                b_we,
  input logic [1:0]          b_addr,
  input logic [DW-1:0]       b_wdata,
  input logic                a_rx_irq,
  input logic                a_tx_irq,
  input logic                b_rx_irq,
  input logic                b_tx_irq,
  input logic [1:0][NCH-1:0] flags,
  input logic [1:0]          rx_en,
  input logic [1:0]          tx_en,
  input logic [1:0][NCH-1:0] occ_msk,
  input logic [1:0][NCH-1:0] free_msk
);
  logic a_sc, b_sc;
  logic [NCH-1:0] a_set, a_clr, b_set, b_clr;
  assign a_sc  = a_sel && a_we && a_addr == 2'd2;
  assign b_sc  = b_sel && b_we && b_addr == 2'd2;
  assign a_set = a_sc ? a_wdata[2*NCH-1:NCH] : '0;
  assign a_clr = a_sc ? a_wdata[NCH-1:0]     : '0;
  assign b_set = b_sc ? b_wdata[2*NCH-1:NCH] : '0;
  assign b_clr = b_sc ? b_wdata[NCH-1:0]     : '0;

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (flags == '0 && occ_msk == '1 && free_msk == '1 &&
                    rx_en == 2'b00 && tx_en == 2'b00 &&
                    !a_rx_irq && !a_tx_irq && !b_rx_irq && !b_tx_irq));

  a_r3_set_raises: assert property (@(posedge clk) disable iff (rst)
    (a_set != '0) |=> ((flags[0] & $past(a_set)) == $past(a_set)));

  a_r4_clear_drops: assert property (@(posedge clk) disable iff (rst)
    ((b_clr & ~a_set) != '0) |=> ((flags[0] & $past(b_clr & ~a_set)) == '0));

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    ((b_set & a_clr) != '0) |=> ((flags[1] & $past(b_set & a_clr)) == $past(b_set & a_clr)));

  a_r3_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!a_sc && !b_sc) |=> $stable(flags));

  a_r6_setclr_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (a_sel && !a_we && a_addr == 2'd2) |=> (a_rdata == '0));

  a_r7_rx_off: assert property (@(posedge clk) disable iff (rst)
    !rx_en[0] |=> !a_rx_irq);

  a_r7_rx_on: assert property (@(posedge clk) disable iff (rst)
    (rx_en[1] && (flags[0] & ~occ_msk[1]) != '0) |=> b_rx_irq);

  a_r8_tx_off: assert property (@(posedge clk) disable iff (rst)
    !tx_en[1] |=> !b_tx_irq);

  a_r8_tx_on: assert property (@(posedge clk) disable iff (rst)
    (tx_en[0] && (~flags[0] & ~free_msk[0]) != '0) |=> a_tx_irq);
endmodule

bind mailbox_flag_ctrl mailbox_flag_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst),
  .a_sel(a_sel), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
  .b_sel(b_sel), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
  .a_rx_irq(a_rx_irq), .a_tx_irq(a_tx_irq), .b_rx_irq(b_rx_irq), .b_tx_irq(b_tx_irq),
  .flags(flags), .rx_en(rx_en), .tx_en(tx_en), .occ_msk(occ_msk), .free_msk(free_msk)
);

// File: tb/mailbox_flag_ctrl_bench.sv
module mailbox_flag_ctrl_bench;
  localparam int NCH = 6;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_sel = 0, a_we = 0, b_sel = 0, b_we = 0;
  logic [1:0] a_addr = 0, b_addr = 0;
  logic [DW-1:0] a_wdata = 0, b_wdata = 0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_rx_irq, a_tx_irq, b_rx_irq, b_tx_irq;

  int checks = 0;
  int errors = 0;

  logic [NCH-1:0] m_flag [2];
  logic [NCH-1:0] m_occ  [2];
  logic [NCH-1:0] m_free [2];
  logic           m_rx   [2];
  logic           m_tx   [2];

  always #5 clk = ~clk;

  mailbox_flag_ctrl #(.NCH(NCH), .DW(DW)) u_mailbox_flag_ctrl (
    .clk(clk), .rst(rst),
    .a_sel(a_sel), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .b_sel(b_sel), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .a_rx_irq(a_rx_irq), .a_tx_irq(a_tx_irq), .b_rx_irq(b_rx_irq), .b_tx_irq(b_tx_irq)
  );

  function automatic logic exp_rx(int p);
    return m_rx[p] && ((m_flag[1-p] & ~m_occ[p]) != '0);
  endfunction

  function automatic logic exp_tx(int p);
    return m_tx[p] && ((~m_flag[p] & ~m_free[p]) != '0);
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin
      m_flag[p] = '0; m_occ[p] = '1; m_free[p] = '1; m_rx[p] = 0; m_tx[p] = 0;
    end
  endtask

  // Write on either or both ports in one cycle, then update the model.
  task automatic wr2(logic ea, logic [1:0] aa, logic [DW-1:0] da,
                     logic eb, logic [1:0] ab, logic [DW-1:0] db);
    logic [NCH-1:0] s0, c0, s1, c1;
    @(negedge clk);
    a_sel = ea; a_we = ea; a_addr = aa; a_wdata = da;
    b_sel = eb; b_we = eb; b_addr = ab; b_wdata = db;
    @(posedge clk);
    @(negedge clk);
    a_sel = 0; a_we = 0; b_sel = 0; b_we = 0;
    s0 = (ea && aa == 2) ? da[2*NCH-1:NCH] : '0;
    c0 = (ea && aa == 2) ? da[NCH-1:0]     : '0;
    s1 = (eb && ab == 2) ? db[2*NCH-1:NCH] : '0;
    c1 = (eb && ab == 2) ? db[NCH-1:0]     : '0;
    m_flag[0] = (m_flag[0] & ~c1) | s0;
    m_flag[1] = (m_flag[1] & ~c0) | s1;
    if (ea && aa == 0) begin m_rx[0] = da[0]; m_tx[0] = da[1]; end
    if (eb && ab == 0) begin m_rx[1] = db[0]; m_tx[1] = db[1]; end
    if (ea && aa == 1) begin m_occ[0] = da[NCH-1:0]; m_free[0] = da[2*NCH-1:NCH]; end
    if (eb && ab == 1) begin m_occ[1] = db[NCH-1:0]; m_free[1] = db[2*NCH-1:NCH]; end
  endtask

  task automatic wr(int p, logic [1:0] ad, logic [DW-1:0] d);
    if (p == 0) wr2(1, ad, d, 0, 0, '0);
    else        wr2(0, 0, '0, 1, ad, d);
  endtask

  task automatic rd(int p, logic [1:0] ad, output logic [DW-1:0] q);
    @(negedge clk);
    if (p == 0) begin a_sel = 1; a_we = 0; a_addr = ad; end
    else        begin b_sel = 1; b_we = 0; b_addr = ad; end
    @(posedge clk);
    @(negedge clk);
    q = (p == 0) ? a_rdata : b_rdata;
    a_sel = 0; b_sel = 0;
  endtask

  task automatic check_irq(string tag);
    @(negedge clk);
    chk({tag, " R7 a_rx"}, DW'(a_rx_irq), DW'(exp_rx(0)));
    chk({tag, " R7 b_rx"}, DW'(b_rx_irq), DW'(exp_rx(1)));
    chk({tag, " R8 a_tx"}, DW'(a_tx_irq), DW'(exp_tx(0)));
    chk({tag, " R8 b_tx"}, DW'(b_tx_irq), DW'(exp_tx(1)));
  endtask

  task automatic check_regs(string tag);
    logic [DW-1:0] q;
    for (int p = 0; p < 2; p++) begin
      rd(p, 2'd3, q); chk({tag, " R5 status"}, q, DW'(m_flag[p]));
      rd(p, 2'd0, q); chk({tag, " R2 R10 ctrl"}, q, DW'({m_tx[p], m_rx[p]}));
      rd(p, 2'd1, q); chk({tag, " R2 R10 mask"}, q, DW'({m_free[p], m_occ[p]}));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] q;
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1: reset values
    chk("R1 irqs", DW'({a_rx_irq, a_tx_irq, b_rx_irq, b_tx_irq}), '0);
    check_regs("R1");

    // R6: set/clear register reads zero even with flags set
    wr(0, 2'd2, DW'({6'b101101, 6'b000000}));
    rd(0, 2'd2, q); chk("R6 setclr read", q, '0);
    check_regs("R3");

    // R5: write to status ignored
    wr(0, 2'd3, '1);
    check_regs("R5 wr-ignored");

    // R4: B clears A's flags, not its own
    wr(1, 2'd2, DW'({6'b000010, 6'b000001}));
    check_regs("R4");

    // R7/R8: enables and unmasking
    wr(1, 2'd0, 32'h3);
    wr(1, 2'd1, DW'({6'b111111, 6'b111011}));
    check_irq("R7 on");
    wr(0, 2'd0, 32'h2);
    wr(0, 2'd1, DW'({6'b111101, 6'b111111}));
    check_irq("R8 on");

    // R9: A sets ch1 while B clears ch1 in the same cycle
    wr2(1, 2'd2, DW'({6'b000010, 6'b000000}), 1, 2'd2, DW'({6'b000000, 6'b000010}));
    check_regs("R9");
    check_irq("R9");

    // R10: config writes on both ports at once stay separate
    wr2(1, 2'd1, 32'h0000_0a5c, 1, 2'd0, 32'h0000_0001);
    check_regs("R10");

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [DW-1:0] da, db;
      logic ea, eb;
      logic [1:0] aa, ab;
      da = $urandom; db = $urandom;
      ea = 1'($urandom); eb = 1'($urandom);
      aa = 2'($urandom); ab = 2'($urandom);
      wr2(ea, aa, da, eb, ab, db);
      check_irq("rand");
      if (i % 4 == 0) check_regs("rand");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule